// File: doc/BRIEF.md
# Static Memory Strobe Timing Generator

This block runs one access to an external static memory, either a read or a write. A single accepted start request opens an address phase of programmed length. Within that phase the block drives an active-low chip-select and one active-low data strobe: the read strobe for reads, the write strobe for writes. Each strobe has its own setup delay and its own low-pulse width. Both are counted from the first clock of the address phase. Whatever time is left in the phase after a strobe's pulse is that strobe's hold time.

Every timing value arrives in a compact coded form. Each code has a coarse high part that scales by a large step and a fine low part that counts single clocks. The block expands these codes into clock counts itself. Reads and writes each have their own set of codes. The block checks the selected set when a start is accepted. A zero pulse, or a strobe that would end after the phase ends, does not produce an access. It produces a one-clock error flag instead. A single-clock done flag marks the last clock of every access that does run.

Top module: `sram_strobe_timer`

## Requirements
- R1: While reset is active, and after it is released, `busy_o`, `done_o` and `cfg_err_o` are 0, and `cs_n_o`, `rd_n_o` and `wr_n_o` are 1. Whenever `busy_o` is 0, all three strobes are 1.
- R2: A 6-bit setup code c decodes to 128·c[5] + c[4:0] clocks. A strobe first goes low at phase clock index equal to its decoded setup. Index 0 is the first clock with `busy_o` high.
- R3: A 7-bit pulse code c decodes to 256·c[6] + c[5:0] clocks. A strobe stays low for exactly that many consecutive clocks, then stays high until the phase ends.
- R4: A 9-bit cycle code c decodes to 256·c[8:7] + c[6:0] clocks. `busy_o` is high for exactly that many clocks. `addr_o` and `be_o` hold the values sampled at start for all of them.
- R5: When `write_i` = 0 at start, `cs_n_o` follows the read chip-select codes, `rd_n_o` follows the read strobe codes, and `wr_n_o` stays 1.
- R6: When `write_i` = 1 at start, `cs_n_o` follows the write chip-select codes, `wr_n_o` follows the write strobe codes, and `rd_n_o` stays 1.
- R7: `done_o` is 1 on the last clock of the phase only. `busy_o` is 0 on the next clock.
- R8: `start_i` is taken only when `busy_o` is 0. A start asserted during a phase neither restarts nor extends it.
- R9: All codes, `write_i`, `addr_i` and `be_i` are sampled when start is taken. Changing them during a phase does not alter that phase.
- R10: If either pulse code of the selected direction is 0, no phase starts. `cfg_err_o` is 1 for the one clock after the start, and `busy_o` stays 0.
- R11: If decoded setup plus decoded pulse of either selected strobe exceeds the decoded cycle, no phase starts. `cfg_err_o` is 1 for one clock, as in R10.
- R12: `rd_n_o` and `wr_n_o` are never 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request one access |
| write_i | input | 1 | 1 = write access, 0 = read access |
| addr_i | input | ADDR_W | Access address |
| be_i | input | BE_W | Byte enables |
| rd_cs_setup_i | input | 6 | Read chip-select setup code |
| rd_cs_pulse_i | input | 7 | Read chip-select pulse code |
| rd_st_setup_i | input | 6 | Read strobe setup code |
| rd_st_pulse_i | input | 7 | Read strobe pulse code |
| rd_cycle_i | input | 9 | Read cycle length code |
| wr_cs_setup_i | input | 6 | Write chip-select setup code |
| wr_cs_pulse_i | input | 7 | Write chip-select pulse code |
| wr_st_setup_i | input | 6 | Write strobe setup code |
| wr_st_pulse_i | input | 7 | Write strobe pulse code |
| wr_cycle_i | input | 9 | Write cycle length code |
| busy_o | output | 1 | Address phase in progress |
| done_o | output | 1 | Last clock of the phase |
| cfg_err_o | output | 1 | One-clock flag for a rejected configuration |
| addr_o | output | ADDR_W | Address held for the phase |
| be_o | output | BE_W | Byte enables held for the phase |
| cs_n_o | output | 1 | Chip-select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |

## Verification
A wrong decode of a coarse bit, or an off-by-one in the phase counter, moves a strobe edge or the end of `busy_o`. That shows up at the ports on the very first clock where the edge should have happened. A wrongly sampled direction or code shows up on the first strobe edge of the phase. A validity check that is too weak or too strict shows up one clock after start: `busy_o` rises when it should not, or `cfg_err_o` does. The bench compares every port on every clock of each access against values it computes itself from the codes. This includes accesses where the inputs are scrambled mid-phase and a second start is requested.

// File: rtl/sst_pkg.sv
package sst_pkg;
  // Coded field widths
  localparam int SU_CW = 6;
  localparam int PU_CW = 7;
  localparam int CY_CW = 9;
  // Decoded widths: coarse bit moves up two places for setup/pulse, one for cycle
  localparam int SU_W = SU_CW + 2;
  localparam int PU_W = PU_CW + 2;
  localparam int CY_W = CY_CW + 1;
  localparam int SUM_W = CY_W + 1;

  typedef struct packed {
    logic [SU_W-1:0] setup;
    logic [PU_W-1:0] pulse;
  } strobe_t;

  // 128*c[5] + c[4:0]
  function automatic logic [SU_W-1:0] dec_setup(input logic [SU_CW-1:0] c);
    return {c[SU_CW-1], 2'b00, c[SU_CW-2:0]};
  endfunction

  // 256*c[6] + c[5:0]
  function automatic logic [PU_W-1:0] dec_pulse(input logic [PU_CW-1:0] c);
    return {c[PU_CW-1], 2'b00, c[PU_CW-2:0]};
  endfunction

  // 256*c[8:7] + c[6:0]
  function automatic logic [CY_W-1:0] dec_cycle(input logic [CY_CW-1:0] c);
    return {c[CY_CW-1:CY_CW-2], 1'b0, c[CY_CW-3:0]};
  endfunction
endpackage

// File: rtl/sst_check.sv
module sst_check
  import sst_pkg::*;
(
  input  logic [CY_W-1:0] cycle,
  input  strobe_t         cs,
  input  strobe_t         st,
  output logic            ok
);
  logic [SUM_W-1:0] cs_end, st_end;
  logic             pulse_ok, fit_ok;

  always_comb begin
    cs_end   = SUM_W'(cs.setup) + SUM_W'(cs.pulse);
    st_end   = SUM_W'(st.setup) + SUM_W'(st.pulse);
    pulse_ok = (cs.pulse != '0) && (st.pulse != '0);
    fit_ok   = (cs_end <= SUM_W'(cycle)) && (st_end <= SUM_W'(cycle));
    ok       = pulse_ok && fit_ok;
  end
endmodule

// File: rtl/sst_seq.sv
module sst_seq
  import sst_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            cfg_ok,
  input  logic [CY_W-1:0] cycle_q,
  output logic            accept,
  output logic            busy,
  output logic [CY_W-1:0] cnt,
  output logic            done,
  output logic            err
);
  logic            busy_q, busy_d, err_q, err_d;
  logic [CY_W-1:0] cnt_q, cnt_d;
  logic            last;

  always_comb begin
    accept = start && !busy_q;
    last   = busy_q && (cnt_q == cycle_q - CY_W'(1));
    busy_d = busy_q;
    cnt_d  = cnt_q;
    err_d  = 1'b0;
    if (accept) begin
      if (cfg_ok) begin
        busy_d = 1'b1;
        cnt_d  = '0;
      end else begin
        err_d  = 1'b1;
      end
    end else if (busy_q) begin
      if (last) busy_d = 1'b0;
      else      cnt_d  = cnt_q + CY_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      err_q  <= err_d;
    end
  end

  assign busy = busy_q;
  assign cnt  = cnt_q;
  assign done = last;
  assign err  = err_q;

  // A running phase advances by one per clock until its last clock
  assert_phase_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !last |=> busy_q && (cnt_q == $past(cnt_q) + CY_W'(1)));
  // A rejected start never opens a phase
  assert_reject_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !busy_q);
endmodule

// File: rtl/sst_strobe.sv
module sst_strobe
  import sst_pkg::*;
(
  input  logic            active,
  input  logic [CY_W-1:0] cnt,
  input  strobe_t         tm,
  output logic            strobe_n
);
  logic [SUM_W-1:0] lo_from, lo_to;

  always_comb begin
    lo_from  = SUM_W'(tm.setup);
    lo_to    = SUM_W'(tm.setup) + SUM_W'(tm.pulse);
    strobe_n = !(active && (SUM_W'(cnt) >= lo_from) && (SUM_W'(cnt) < lo_to));
  end
endmodule

// File: rtl/sram_strobe_timer.sv
module sram_strobe_timer
  import sst_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BE_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [SU_CW-1:0]  rd_cs_setup_i,
  input  logic [PU_CW-1:0]  rd_cs_pulse_i,
  input  logic [SU_CW-1:0]  rd_st_setup_i,
  input  logic [PU_CW-1:0]  rd_st_pulse_i,
  input  logic [CY_CW-1:0]  rd_cycle_i,
  input  logic [SU_CW-1:0]  wr_cs_setup_i,
  input  logic [PU_CW-1:0]  wr_cs_pulse_i,
  input  logic [SU_CW-1:0]  wr_st_setup_i,
  input  logic [PU_CW-1:0]  wr_st_pulse_i,
  input  logic [CY_CW-1:0]  wr_cycle_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cfg_err_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BE_W-1:0]   be_o,
  output logic              cs_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o
);
  localparam int N_STROBES = 2;  // 0: chip-select, 1: data strobe

  // Reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  // Live decode of the selected direction
  strobe_t         live_tm [N_STROBES];
  logic [CY_W-1:0] live_cyc;
  always_comb begin
    if (write_i) begin
      live_tm[0] = '{setup: dec_setup(wr_cs_setup_i), pulse: dec_pulse(wr_cs_pulse_i)};
      live_tm[1] = '{setup: dec_setup(wr_st_setup_i), pulse: dec_pulse(wr_st_pulse_i)};
      live_cyc   = dec_cycle(wr_cycle_i);
    end else begin
      live_tm[0] = '{setup: dec_setup(rd_cs_setup_i), pulse: dec_pulse(rd_cs_pulse_i)};
      live_tm[1] = '{setup: dec_setup(rd_st_setup_i), pulse: dec_pulse(rd_st_pulse_i)};
      live_cyc   = dec_cycle(rd_cycle_i);
    end
  end

  logic cfg_ok, accept, busy, done, err;
  logic [CY_W-1:0] cnt;

  sst_check u_check (
    .cycle (live_cyc),
    .cs    (live_tm[0]),
    .st    (live_tm[1]),
    .ok    (cfg_ok)
  );

  // Captured access parameters
  strobe_t           tm_q [N_STROBES];
  logic [CY_W-1:0]   cyc_q;
  logic              dir_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BE_W-1:0]   be_q;
  logic              cap_en;

  assign cap_en = accept && cfg_ok;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cyc_q  <= CY_W'(3);
      dir_q  <= 1'b0;
      addr_q <= '0;
      be_q   <= '0;
    end else if (cap_en) begin
      cyc_q  <= live_cyc;
      dir_q  <= write_i;
      addr_q <= addr_i;
      be_q   <= be_i;
    end
  end

  sst_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .start   (start_i),
    .cfg_ok  (cfg_ok),
    .cycle_q (cyc_q),
    .accept  (accept),
    .busy    (busy),
    .cnt     (cnt),
    .done    (done),
    .err     (err)
  );

  logic strobe_n [N_STROBES];

  for (genvar g = 0; g < N_STROBES; g++) begin : g_strobe
    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n) tm_q[g] <= '{setup: SU_W'(1), pulse: PU_W'(1)};
      else if (cap_en) tm_q[g] <= live_tm[g];
    end

    sst_strobe u_strobe (
      .active   (busy),
      .cnt      (cnt),
      .tm       (tm_q[g]),
      .strobe_n (strobe_n[g])
    );
  end

  assign busy_o    = busy;
  assign done_o    = done;
  assign cfg_err_o = err;
  assign addr_o    = addr_q;
  assign be_o      = be_q;
  assign cs_n_o    = strobe_n[0];
  assign rd_n_o    = dir_q  | strobe_n[1];
  assign wr_n_o    = !dir_q | strobe_n[1];

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    !busy_o |-> cs_n_o && rd_n_o && wr_n_o);
  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    busy_o && $past(busy_o) |-> $stable(addr_o) && $stable(be_o));
  assert_done_ends_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    done_o |=> !busy_o);
  assert_done_busy_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    done_o |-> busy_o);
  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_s_n)
    rd_n_o || wr_n_o);
endmodule

// File: tb/sim_sram_strobe_timer.sv
module sim_sram_strobe_timer;
  localparam int AW = 24;
  localparam int BW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, write_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [BW-1:0] be_i = '0;
  logic [5:0] rd_cs_s = '0, rd_st_s = '0, wr_cs_s = '0, wr_st_s = '0;
  logic [6:0] rd_cs_p = '0, rd_st_p = '0, wr_cs_p = '0, wr_st_p = '0;
  logic [8:0] rd_cyc = '0, wr_cyc = '0;
  logic busy_o, done_o, cfg_err_o, cs_n_o, rd_n_o, wr_n_o;
  logic [AW-1:0] addr_o;
  logic [BW-1:0] be_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sram_strobe_timer #(.ADDR_W(AW), .BE_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i),
    .addr_i(addr_i), .be_i(be_i),
    .rd_cs_setup_i(rd_cs_s), .rd_cs_pulse_i(rd_cs_p),
    .rd_st_setup_i(rd_st_s), .rd_st_pulse_i(rd_st_p), .rd_cycle_i(rd_cyc),
    .wr_cs_setup_i(wr_cs_s), .wr_cs_pulse_i(wr_cs_p),
    .wr_st_setup_i(wr_st_s), .wr_st_pulse_i(wr_st_p), .wr_cycle_i(wr_cyc),
    .busy_o(busy_o), .done_o(done_o), .cfg_err_o(cfg_err_o),
    .addr_o(addr_o), .be_o(be_o), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o)
  );

  function automatic int f_setup(input logic [5:0] c);
    return (c[5] ? 128 : 0) + int'(c[4:0]);
  endfunction
  function automatic int f_pulse(input logic [6:0] c);
    return (c[6] ? 256 : 0) + int'(c[5:0]);
  endfunction
  function automatic int f_cycle(input logic [8:0] c);
    return 256 * int'(c[8:7]) + int'(c[6:0]);
  endfunction
  function automatic bit f_valid(input logic [5:0] cs_s, input logic [6:0] cs_p,
                                 input logic [5:0] st_s, input logic [6:0] st_p,
                                 input logic [8:0] cy);
    if (cs_p == 0 || st_p == 0) return 0;
    if (f_setup(cs_s) + f_pulse(cs_p) > f_cycle(cy)) return 0;
    if (f_setup(st_s) + f_pulse(st_p) > f_cycle(cy)) return 0;
    return 1;
  endfunction
  function automatic bit f_low(input int k, input int c, input int s, input int p);
    return (k < c) && (k >= s) && (k < s + p);
  endfunction

  task automatic chk(input bit good, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp(input string req, input string what, input longint act, input longint exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic scramble_inputs();
    rd_cs_s = 6'($urandom); rd_cs_p = 7'($urandom); rd_st_s = 6'($urandom);
    rd_st_p = 7'($urandom); rd_cyc = 9'($urandom);
    wr_cs_s = 6'($urandom); wr_cs_p = 7'($urandom); wr_st_s = 6'($urandom);
    wr_st_p = 7'($urandom); wr_cyc = 9'($urandom);
    write_i = 1'($urandom); addr_i = AW'($urandom); be_i = BW'($urandom);
  endtask

  // Runs one access; called at a negedge, returns at a negedge with the block idle
  task automatic access(input bit wr, input logic [5:0] cs_s, input logic [6:0] cs_p,
                        input logic [5:0] st_s, input logic [6:0] st_p,
                        input logic [8:0] cy, input bit scr, input string rej_tag);
    int c, scs, pcs, sst, pst;
    bit ok;
    logic [AW-1:0] a;
    logic [BW-1:0] b;
    string tg, dtg;
    scramble_inputs();
    if (wr) begin
      wr_cs_s = cs_s; wr_cs_p = cs_p; wr_st_s = st_s; wr_st_p = st_p; wr_cyc = cy;
    end else begin
      rd_cs_s = cs_s; rd_cs_p = cs_p; rd_st_s = st_s; rd_st_p = st_p; rd_cyc = cy;
    end
    write_i = wr;
    a = addr_i; b = be_i;
    c = f_cycle(cy); scs = f_setup(cs_s); pcs = f_pulse(cs_p);
    sst = f_setup(st_s); pst = f_pulse(st_p);
    ok = f_valid(cs_s, cs_p, st_s, st_p, cy);
    if (ok && c < 2) scr = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (!ok) begin
      cmp(rej_tag, "cfg_err_o", cfg_err_o, 1);
      cmp(rej_tag, "busy_o", busy_o, 0);
      cmp(rej_tag, "strobes", {cs_n_o, rd_n_o, wr_n_o}, 3'b111);
      @(negedge clk);
      cmp(rej_tag, "cfg_err_o after", cfg_err_o, 0);
      cmp(rej_tag, "busy_o after", busy_o, 0);
      return;
    end
    tg  = scr ? " R8 R9" : "";
    dtg = wr ? "R6 R2 R3" : "R5 R2 R3";
    for (int k = 0; k <= c + 1; k++) begin
      cmp({"R4", tg}, "busy_o", busy_o, (k < c));
      cmp({"R7", tg}, "done_o", done_o, (k == c - 1));
      cmp("R10 R11", "cfg_err_o", cfg_err_o, 0);
      cmp({dtg, tg}, "cs_n_o", cs_n_o, !f_low(k, c, scs, pcs));
      cmp({dtg, tg}, "rd_n_o", rd_n_o, wr ? 1 : !f_low(k, c, sst, pst));
      cmp({dtg, tg}, "wr_n_o", wr_n_o, wr ? !f_low(k, c, sst, pst) : 1);
      chk(rd_n_o || wr_n_o, "R12", "rd_n_o&wr_n_o", {rd_n_o, wr_n_o}, 2'b11);
      if (k < c) begin
        cmp({"R4", tg}, "addr_o", addr_o, a);
        cmp({"R4", tg}, "be_o", be_o, b);
      end
      if (scr && k == 0) begin
        scramble_inputs();
        start_i = 1'b1;
      end
      if (scr && k == c - 1) start_i = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'h0005_EED5));
    #1;
    // R1: during reset
    cmp("R1", "busy_o in reset", busy_o, 0);
    cmp("R1", "done/err in reset", {done_o, cfg_err_o}, 2'b00);
    cmp("R1", "strobes in reset", {cs_n_o, rd_n_o, wr_n_o}, 3'b111);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp("R1", "busy_o after reset", busy_o, 0);
    cmp("R1", "done/err after reset", {done_o, cfg_err_o}, 2'b00);
    cmp("R1", "strobes after reset", {cs_n_o, rd_n_o, wr_n_o}, 3'b111);

    // Directed corners
    access(0, 6'd1, 7'd1, 6'd1, 7'd1, 9'd3, 0, "R10");                    // small read
    access(1, 6'b100000, 7'd1, 6'b100001, 7'd2, 9'b010000000, 0, "R11");   // coarse setup R2
    access(0, 6'd0, 7'b1000000, 6'd0, 7'b1000000, 9'b010000000, 0, "R11"); // coarse pulse, exact fit R3
    access(1, 6'd0, 7'd5, 6'd31, 7'b1111111, 9'b111111111, 0, "R11");      // top cycle band R4
    access(0, 6'd0, 7'd1, 6'd0, 7'd1, 9'd1, 0, "R11");                     // one-clock phase
    access(0, 6'd0, 7'd4, 6'd1, 7'd2, 9'd6, 1, "R11");                     // R8 R9 scrambled read
    access(1, 6'd2, 7'd3, 6'd0, 7'd5, 9'd7, 1, "R11");                     // R8 R9 scrambled write
    access(0, 6'd1, 7'd0, 6'd1, 7'd1, 9'd5, 0, "R10");                     // zero cs pulse
    access(1, 6'd1, 7'd1, 6'd1, 7'd0, 9'd5, 0, "R10");                     // zero strobe pulse
    access(0, 6'd2, 7'd2, 6'd0, 7'd1, 9'd3, 0, "R11");                     // overflow by one
    access(1, 6'd0, 7'd1, 6'd0, 7'd1, 9'd0, 0, "R11");                     // zero cycle

    // Constrained random
    for (int i = 0; i < 40; i++) begin
      logic [5:0] cs_s, st_s;
      logic [6:0] cs_p, st_p;
      logic [8:0] cy;
      cy = {2'($urandom_range(0, 3) == 3 ? $urandom : 0), 7'($urandom)};
      cs_s = 6'($urandom); st_s = 6'($urandom);
      cs_p = 7'($urandom); st_p = 7'($urandom);
      if (i % 4 != 0) begin
        for (int t = 0; t < 30 && !f_valid(cs_s, cs_p, st_s, st_p, cy); t++) begin
          cs_s = 6'($urandom_range(0, 31)); st_s = 6'($urandom_range(0, 31));
          cs_p = 7'($urandom_range(1, 63)); st_p = 7'($urandom_range(1, 63));
        end
      end
      access(1'($urandom), cs_s, cs_p, st_s, st_p, cy, (i % 5 == 2), "R10 R11");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule